// File: doc/BRIEF.md
# Dual-Port Refresh Access Arbiter

This block decides, once per idle slot of a shared DRAM array, which of three requesters may start the next operation: a refresh request, CPU port A or CPU port B. The two CPU ports share a single address input, so the block drives a steering flag that tells external buffers which port's address to pass. Each winning operation is announced by a one-cycle start pulse. The array then counts as busy for a fixed number of cycles, which is set by a parameter for CPU accesses and by another for refresh. The block does not generate any DRAM strobe timing.

The port that loses arbitration is stalled. Port A sees a wait level. Port B receives an early transfer acknowledge only after its own access has begun. A lock input lets the port that currently owns the array keep it across back-to-back accesses. While the lock is held, the other port and refresh are both shut out. When both ports contend without a lock, the winner alternates, so neither port can starve the other.

Top module: `dpra_top`

## Requirements
- R1: During and right after synchronous reset, `grant_b` is 0, all three start pulses are 0, `ack_b` is 0, and the array is idle.
- R2: If the array is idle and a CPU request wins in a cycle, the matching start pulse (`start_a` or `start_b`) is high for exactly the next cycle. The access then keeps the array busy for ACC_CYC cycles, counting from the pulse cycle, and is followed by at least one idle cycle before any other start.
- R3: When the array is idle, not locked, and `rfsh_req` is high, refresh wins over any CPU request. `rfsh_start` pulses in the next cycle, and the array stays busy for RFSH_CYC cycles counting from that pulse.
- R4: `grant_b` changes only on the same edge that raises a CPU start pulse. It is 1 after a port-B start and 0 after a port-A start, and it holds its value during refresh and idle time.
- R5: When both ports request at an unlocked idle slot with no refresh pending, port A wins if no CPU access has started since reset. Otherwise the port that did not win the most recent CPU start wins.
- R6: A lock becomes active when a CPU access starts while `lock` is high, and it stays active for as long as `lock` remains high. While it is active, only the owning port (the one indicated by `grant_b`) may start. Neither the other port nor refresh starts until `lock` goes low.
- R7: `ack_b` is high for exactly the one cycle that follows each `start_b` pulse, and is never high at any other time.
- R8: `wait_a` equals `req_a`, except while a port-A access is in progress (from its start pulse to its last busy cycle), when it is 0. This is a combinational function of the current `req_a`.
- R9: At most one of `start_a`, `start_b` and `rfsh_start` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_a | input | 1 | Port A access request (level, held until its start pulse) |
| req_b | input | 1 | Port B access request (level, held until its start pulse) |
| rfsh_req | input | 1 | Refresh request (level, held until refresh start) |
| lock | input | 1 | Owning port keeps the array while high |
| grant_b | output | 1 | 1 when port B owns the shared address path |
| start_a | output | 1 | One-cycle pulse: port A access begins |
| start_b | output | 1 | One-cycle pulse: port B access begins |
| rfsh_start | output | 1 | One-cycle pulse: refresh begins |
| ack_b | output | 1 | Early transfer acknowledge for port B |
| wait_a | output | 1 | Wait state for port A |

## Verification
The bench builds the block with ACC_CYC = 2 and RFSH_CYC = 3. These short windows let thousands of complete arbitration rounds, including back-to-back and locked runs, fit into a short run. The bench sweeps all sixteen held combinations of the two port requests, refresh and lock. It also covers a long pseudo-random stretch with toggling lock, and directed sequences for alternation under constant contention and for refresh being held off by a lock. The minimum busy lengths bring the one-cycle idle gap and the acknowledge pulse close together, so any off-by-one error in the counter or the pulse timing appears on the ports.

// File: rtl/dpra_pkg.sv
package dpra_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CPU  = 2'd1,
        ST_RFSH = 2'd2
    } arb_state_e;

    typedef enum logic [1:0] {
        PICK_NONE = 2'd0,
        PICK_A    = 2'd1,
        PICK_B    = 2'd2,
        PICK_RFSH = 2'd3
    } pick_e;

    typedef struct packed {
        logic port_a;
        logic port_b;
        logic rfsh;
    } req_vec_t;

    typedef struct packed {
        logic go_a;
        logic go_b;
        logic go_rf;
    } start_vec_t;

    function automatic int busy_cnt_width(input int acc_cyc, input int rf_cyc);
        int m;
        m = (acc_cyc > rf_cyc) ? acc_cyc : rf_cyc;
        return $clog2(m) + 1;
    endfunction

endpackage

// File: rtl/dpra_pick.sv
module dpra_pick
    import dpra_pkg::*;
(
    input  req_vec_t reqs,
    input  logic     locked,
    input  logic     owner_b,
    input  logic     turn_b,
    output pick_e    pick
);
    logic owner_req;

    always_comb begin
        owner_req = owner_b ? reqs.port_b : reqs.port_a;
        pick = PICK_NONE;
        if (locked) begin
            if (owner_req) pick = owner_b ? PICK_B : PICK_A;
        end else if (reqs.rfsh) begin
            pick = PICK_RFSH;
        end else if (reqs.port_a && reqs.port_b) begin
            pick = turn_b ? PICK_B : PICK_A;
        end else if (reqs.port_a) begin
            pick = PICK_A;
        end else if (reqs.port_b) begin
            pick = PICK_B;
        end
    end
endmodule

// File: rtl/dpra_seq.sv
module dpra_seq
    import dpra_pkg::*;
#(
    parameter int ACC_CYC  = 4,
    parameter int RFSH_CYC = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  pick_e      pick,
    output start_vec_t starts,
    output logic       idle,
    output logic       cpu_busy
);
    localparam int CW = busy_cnt_width(ACC_CYC, RFSH_CYC);
    localparam logic [CW-1:0] ACC_LOAD = CW'(ACC_CYC - 1);
    localparam logic [CW-1:0] RF_LOAD  = CW'(RFSH_CYC - 1);

    arb_state_e    state;
    logic [CW-1:0] remain;

    assign idle     = (state == ST_IDLE);
    assign cpu_busy = (state == ST_CPU);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            remain <= '0;
            starts <= '0;
        end else begin
            starts <= '0;
            case (state)
                ST_IDLE: begin
                    case (pick)
                        PICK_A: begin
                            state       <= ST_CPU;
                            remain      <= ACC_LOAD;
                            starts.go_a <= 1'b1;
                        end
                        PICK_B: begin
                            state       <= ST_CPU;
                            remain      <= ACC_LOAD;
                            starts.go_b <= 1'b1;
                        end
                        PICK_RFSH: begin
                            state        <= ST_RFSH;
                            remain       <= RF_LOAD;
                            starts.go_rf <= 1'b1;
                        end
                        default: ;
                    endcase
                end
                ST_CPU, ST_RFSH: begin
                    if (remain == '0) state <= ST_IDLE;
                    else              remain <= remain - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R9
    single_start_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({starts.go_a, starts.go_b, starts.go_rf}));

    // R2
    start_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (starts.go_a || starts.go_b || starts.go_rf) |=>
            !(starts.go_a || starts.go_b || starts.go_rf));
endmodule

// File: rtl/dpra_lock.sv
module dpra_lock (
    input  logic clk,
    input  logic rst,
    input  logic lock,
    input  logic cpu_launch,
    output logic lock_active
);
    always_ff @(posedge clk) begin
        if (rst) lock_active <= 1'b0;
        else     lock_active <= lock && (lock_active || cpu_launch);
    end

    // R6
    lock_release_chk: assert property (@(posedge clk) disable iff (rst)
        !lock |=> !lock_active);
endmodule

// File: rtl/dpra_top.sv
module dpra_top
    import dpra_pkg::*;
#(
    parameter int ACC_CYC  = 4,
    parameter int RFSH_CYC = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic req_a,
    input  logic req_b,
    input  logic rfsh_req,
    input  logic lock,
    output logic grant_b,
    output logic start_a,
    output logic start_b,
    output logic rfsh_start,
    output logic ack_b,
    output logic wait_a
);
    req_vec_t   reqs;
    pick_e      pick;
    start_vec_t starts;
    logic       idle;
    logic       cpu_busy;
    logic       lock_active;
    logic       locked;
    logic       turn_b;
    logic       launch_a;
    logic       launch_b;

    assign reqs     = '{port_a: req_a, port_b: req_b, rfsh: rfsh_req};
    assign locked   = lock_active && lock;
    assign launch_a = idle && (pick == PICK_A);
    assign launch_b = idle && (pick == PICK_B);

    dpra_pick u_pick (
        .reqs    (reqs),
        .locked  (locked),
        .owner_b (grant_b),
        .turn_b  (turn_b),
        .pick    (pick)
    );

    dpra_seq #(.ACC_CYC(ACC_CYC), .RFSH_CYC(RFSH_CYC)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .pick     (pick),
        .starts   (starts),
        .idle     (idle),
        .cpu_busy (cpu_busy)
    );

    dpra_lock u_lock (
        .clk         (clk),
        .rst         (rst),
        .lock        (lock),
        .cpu_launch  (launch_a || launch_b),
        .lock_active (lock_active)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_b <= 1'b0;
            turn_b  <= 1'b0;
            ack_b   <= 1'b0;
        end else begin
            ack_b <= starts.go_b;
            if (launch_a) begin
                grant_b <= 1'b0;
                turn_b  <= 1'b1;
            end else if (launch_b) begin
                grant_b <= 1'b1;
                turn_b  <= 1'b0;
            end
        end
    end

    assign start_a    = starts.go_a;
    assign start_b    = starts.go_b;
    assign rfsh_start = starts.go_rf;
    assign wait_a     = req_a && !(cpu_busy && !grant_b);

    // R4
    grant_move_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(grant_b) |-> (start_a || start_b));

    // R7
    ack_follow_chk: assert property (@(posedge clk) disable iff (rst)
        start_b |=> ack_b);

    // R7
    ack_origin_chk: assert property (@(posedge clk) disable iff (rst)
        ack_b |-> $past(start_b));

    // R6
    lock_no_rfsh_chk: assert property (@(posedge clk) disable iff (rst)
        (lock_active && lock) |=> !rfsh_start);

    // R6
    lock_no_intruder_chk: assert property (@(posedge clk) disable iff (rst)
        (lock_active && lock && !grant_b) |=> !start_b);
endmodule

// File: tb/dpra_top_test.sv
module dpra_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int ACC  = 2;
    localparam int RFSH = 3;
    localparam int LIMIT = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pa = 1'b0, pb = 1'b0, pr = 1'b0, lk = 1'b0;
    logic grant_b, start_a, start_b, rfsh_start, ack_b, wait_a;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // reference state: 0 idle, 1 port A busy, 2 port B busy, 3 refresh busy
    int   m_st = 0, m_left = 0;
    logic m_gb = 0, m_turn = 0, m_lk = 0;
    logic m_sa = 0, m_sb = 0, m_sr = 0, m_ack = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpra_top #(.ACC_CYC(ACC), .RFSH_CYC(RFSH)) uut (
        .clk(clk), .rst(rst), .req_a(pa), .req_b(pb), .rfsh_req(pr), .lock(lk),
        .grant_b(grant_b), .start_a(start_a), .start_b(start_b),
        .rfsh_start(rfsh_start), .ack_b(ack_b), .wait_a(wait_a)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic model_step();
        logic held, who_b, go_a, go_b, go_r;
        if (rst) begin
            m_st = 0; m_left = 0; m_gb = 0; m_turn = 0; m_lk = 0;
            m_sa = 0; m_sb = 0; m_sr = 0; m_ack = 0;
            return;
        end
        m_ack = m_sb;
        go_a = 0; go_b = 0; go_r = 0;
        if (m_st == 0) begin
            held = m_lk && lk;
            if (held) begin
                if (m_gb && pb) go_b = 1;
                if (!m_gb && pa) go_a = 1;
            end else if (pr) go_r = 1;
            else if (pa || pb) begin
                who_b = (pa && pb) ? m_turn : pb;
                go_a = !who_b; go_b = who_b;
            end
        end else if (m_left == 0) m_st = 0;
        else m_left--;
        m_lk = lk && (m_lk || go_a || go_b);
        if (go_a) begin m_st = 1; m_left = ACC - 1; m_gb = 0; m_turn = 1; end
        if (go_b) begin m_st = 2; m_left = ACC - 1; m_gb = 1; m_turn = 0; end
        if (go_r) begin m_st = 3; m_left = RFSH - 1; end
        m_sa = go_a; m_sb = go_b; m_sr = go_r;
    endtask

    // one cycle: advance model, compare ports, requesters drop on their start
    task automatic tick();
        @(negedge clk);
        model_step();
        chk("R2 R5 R6", "start_a", start_a, m_sa);
        chk("R2 R5 R6", "start_b", start_b, m_sb);
        chk("R3 R6", "rfsh_start", rfsh_start, m_sr);
        chk("R4", "grant_b", grant_b, m_gb);
        chk("R7", "ack_b", ack_b, m_ack);
        chk("R8", "wait_a", wait_a, pa && (m_st != 1));
        chk("R9", "start count<=1", ((32'(start_a) + 32'(start_b) + 32'(rfsh_start)) <= 1), 1'b1);
        if (start_a) pa = 0;
        if (start_b) pb = 0;
        if (rfsh_start) pr = 0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > LIMIT) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, LIMIT);
            finish_run();
        end
    end

    initial begin
        logic [15:0] lfsr;
        int nstart;
        rst = 1;
        @(posedge clk);
        repeat (2) tick();
        // R1 reset state
        chk("R1", "grant_b after reset", grant_b, 1'b0);
        chk("R1", "starts after reset", start_a | start_b | rfsh_start, 1'b0);
        chk("R1", "ack_b after reset", ack_b, 1'b0);
        rst = 0;
        tick();
        chk("R1", "idle start quiet", start_a | start_b | rfsh_start, 1'b0);

        // R5: constant contention alternates, A first after reset
        nstart = 0;
        for (int i = 0; i < 60 && nstart < 6; i++) begin
            pa = 1; pb = 1;
            tick();
            if (start_a || start_b) begin
                chk("R5", "alternating winner is A", start_a, (nstart % 2) == 0);
                nstart++;
            end
        end
        chk("R5", "six contended starts seen", nstart == 6, 1'b1);
        while (pa || pb) tick();
        repeat (4) tick();

        // R6: A locks, B and refresh shut out; R3 refresh first after release
        lk = 1; pa = 1;
        nstart = 0;
        for (int i = 0; i < 30; i++) begin
            if (i > 2) begin pb = 1; pr = 1; pa = 1; end
            tick();
            if (i > 3) begin
                chk("R6", "no port B start under lock", start_b, 1'b0);
                chk("R6", "no refresh under lock", rfsh_start, 1'b0);
            end
            if (start_a) nstart++;
        end
        chk("R6", "owner kept starting", nstart >= 5, 1'b1);
        lk = 0; pa = 0;
        for (int i = 0; i < 10; i++) begin
            tick();
            if (start_a || start_b || rfsh_start) begin
                chk("R3", "refresh wins after unlock", rfsh_start, 1'b1);
                break;
            end
        end
        for (int i = 0; i < 20; i++) tick();
        pa = 0; pb = 0; pr = 0;
        repeat (6) tick();

        // sweep all held combinations of requests and lock, re-raising each cycle
        for (int c = 0; c < 16; c++) begin
            for (int i = 0; i < 24; i++) begin
                pa = c[0]; pb = c[1]; pr = c[2]; lk = c[3];
                tick();
            end
            pa = 0; pb = 0; pr = 0; lk = 0;
            repeat (6) tick();
        end

        // pseudo-random traffic with toggling lock
        lfsr = 16'hACE1;
        for (int i = 0; i < 5000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[0] && lfsr[3]) pa = 1;
            if (lfsr[5] && lfsr[7]) pb = 1;
            if (lfsr[10:8] == 3'd0) pr = 1;
            if (lfsr[15:13] == 3'd0) lk = ~lk;
            tick();
        end
        lk = 0;
        repeat (20) tick();
        finish_run();
    end
endmodule